// File: doc/BRIEF.md
# Ready/Busy Status Pin Configurator

This block drives the ready/busy status pin of a flash-style memory command interface. The pin is modelled as an open-drain line: a value of 1 means released (high, ready) and 0 means pulled low. A two-bit configuration code picks one of four behaviours. In level mode the pin reflects the busy flag of the write state machine. In the three pulse modes the pin is pulled low for a fixed number of clock cycles each time a selected completion event occurs. The selectable events are erase done, program done, or either of the two.

Software changes the configuration through a write port. Each write carries an 8-bit key and an 8-bit data byte. A write is accepted only when the key matches the `CFG_KEY` parameter. Only the two low data bits hold the mode code; the upper six bits are reserved. A write with the wrong key leaves the configuration as it was and sets two sticky error flags in the status register. A clear-status strobe resets both flags. The erase and program algorithms sit outside this block; it sees only their busy flag and one-cycle completion strobes.

Top module: `rdy_status_pin`

## Requirements
- R1: While reset is held, and after it is released with the busy flag low and no events, the pin is high, both error flags are 0 and the mode is level (code 00).
- R2: In level mode (code 00) the pin equals the inverse of `busy_i` sampled at the previous clock edge. Completion strobes have no effect on the pin in this mode.
- R3: With code 01 an `erase_done_i` strobe starts a low pulse. A `prog_done_i` strobe alone does not.
- R4: With code 10 a `prog_done_i` strobe starts a low pulse. An `erase_done_i` strobe alone does not.
- R5: With code 11 either strobe starts a low pulse.
- R6: A pulse holds the pin low for exactly `PULSE_CYC` consecutive cycles. The pulse begins in the cycle after the strobe's clock edge.
- R7: A selected strobe that arrives during an active pulse restarts the full `PULSE_CYC` count from that edge. No second pulse is queued.
- R8: A write whose key differs from `CFG_KEY` sets both error flags (status bits 5 and 4) at the next edge and leaves the mode unchanged.
- R9: On an accepted write, only `cfg_data_i[1:0]` sets the mode. Bits [7:2] are ignored.
- R10: The error flags keep their value until `clr_status_i` clears them both at the next edge. If a rejected write arrives in the same cycle as a clear, the flags are set.
- R11: An accepted configuration write ends any active pulse, so the pin is high in the next cycle. A strobe arriving in the same cycle as the write is judged under the old mode, and the write's abort takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy_i | input | 1 | Write state machine busy flag |
| erase_done_i | input | 1 | One-cycle erase completion strobe |
| prog_done_i | input | 1 | One-cycle program completion strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_key_i | input | 8 | Write key, must equal CFG_KEY to be accepted |
| cfg_data_i | input | 8 | Configuration data; [1:0] mode code, [7:2] reserved |
| clr_status_i | input | 1 | Clears both error flags |
| sts_o | output | 1 | Status pin: 1 released/high, 0 pulled low |
| err_b5_o | output | 1 | Status bit 5 error flag |
| err_b4_o | output | 1 | Status bit 5's companion, status bit 4 error flag |

## Verification
The hardest case to reach from the ports is a strobe that lands during a pulse that is already running. The restarted pulse has to be told apart from one pulse followed by a queued second one. A related case is a configuration write that cuts a pulse short in the same cycle as an event. Directed sequences fire a second erase strobe a few cycles into a pulse and check that the total low run is that offset plus `PULSE_CYC`. They also issue a write in mid-pulse. Random phases then mix dense strobes, rejected-key writes and clears in every mode, and compare each cycle against a bench reference model.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  // Mode code: bit 0 enables erase events, bit 1 enables program events.
  typedef enum logic [1:0] {
    STS_LEVEL = 2'b00,
    STS_ERASE = 2'b01,
    STS_PROG  = 2'b10,
    STS_ANY   = 2'b11
  } sts_mode_e;

endpackage

// File: rtl/rsp_rst_sync.sv
module rsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/rsp_cfg_reg.sv
module rsp_cfg_reg
  import rsp_pkg::*;
#(
  parameter int unsigned     KEY_W   = 8,
  parameter logic [KEY_W-1:0] CFG_KEY = 8'h5C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [1:0]       code_i,
  input  logic             clr_i,
  output sts_mode_e        mode_o,
  output logic             load_o,
  output logic             err_o
);

  sts_mode_e mode_q, mode_d;
  logic      err_q, err_d;
  logic      key_ok, bad_wr;

  assign key_ok = (key_i == CFG_KEY);
  assign load_o = wr_i & key_ok;
  assign bad_wr = wr_i & ~key_ok;

  always_comb begin
    mode_d = mode_q;
    if (load_o) mode_d = sts_mode_e'(code_i);
  end

  always_comb begin
    err_d = err_q;
    if (bad_wr)     err_d = 1'b1;
    else if (clr_i) err_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= STS_LEVEL;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

endmodule

// File: rtl/rsp_event_sel.sv
module rsp_event_sel
  import rsp_pkg::*;
(
  input  sts_mode_e mode_i,
  input  logic      erase_i,
  input  logic      prog_i,
  output logic      fire_o
);

  logic [1:0] mask;
  logic [1:0] evt;

  assign mask = mode_i;
  assign evt  = {prog_i, erase_i};

  // Level mode has an all-zero mask, so no event fires there.
  assign fire_o = |(mask & evt);

endmodule

// File: rtl/rsp_pulse_gen.sv
module rsp_pulse_gen #(
  parameter int unsigned PULSE_CYC = 50,
  localparam int unsigned CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic fire_i,
  output logic active_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = abort_i | fire_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (abort_i)            cnt_d = '0;
    else if (fire_i)        cnt_d = CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/rdy_status_pin.sv
module rdy_status_pin
  import rsp_pkg::*;
#(
  parameter int unsigned      PULSE_CYC = 50,
  parameter int unsigned      DATA_W    = 8,
  parameter logic [DATA_W-1:0] CFG_KEY  = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              erase_done_i,
  input  logic              prog_done_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] cfg_key_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              clr_status_i,
  output logic              sts_o,
  output logic              err_b5_o,
  output logic              err_b4_o
);

  logic      rst_n_s;
  sts_mode_e mode_w;
  logic      load_w, err_w, fire_w, pulse_w;
  logic      lvl_q, lvl_d;
  logic      unused_rsvd;

  assign unused_rsvd = ^cfg_data_i[DATA_W-1:2];

  rsp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  rsp_cfg_reg #(.KEY_W(DATA_W), .CFG_KEY(CFG_KEY)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .wr_i  (cfg_wr_i),
    .key_i (cfg_key_i),
    .code_i(cfg_data_i[1:0]),
    .clr_i (clr_status_i),
    .mode_o(mode_w),
    .load_o(load_w),
    .err_o (err_w)
  );

  rsp_event_sel u_sel (
    .mode_i (mode_w),
    .erase_i(erase_done_i),
    .prog_i (prog_done_i),
    .fire_o (fire_w)
  );

  rsp_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .abort_i (load_w),
    .fire_i  (fire_w),
    .active_o(pulse_w)
  );

  assign lvl_d = ~busy_i;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) lvl_q <= 1'b1;
    else          lvl_q <= lvl_d;
  end

  assign sts_o    = (mode_w == STS_LEVEL) ? lvl_q : ~pulse_w;
  assign err_b5_o = err_w;
  assign err_b4_o = err_w;

endmodule

// File: rtl/rsp_chk.sv
module rsp_chk
  import rsp_pkg::*;
#(
  parameter int unsigned      PULSE_CYC = 50,
  parameter int unsigned      DATA_W    = 8,
  parameter logic [DATA_W-1:0] CFG_KEY  = 8'h5C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              erase_done_i,
  input logic              prog_done_i,
  input logic              cfg_wr_i,
  input logic [DATA_W-1:0] cfg_key_i,
  input logic              clr_status_i,
  input sts_mode_e         mode_i,
  input logic              sts_o,
  input logic              err_b5_o,
  input logic              err_b4_o
);

  logic [31:0] since_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         since_evt <= '0;
    else if (erase_done_i | prog_done_i) since_evt <= '0;
    else if (!sts_o)                     since_evt <= since_evt + 1;
    else                                 since_evt <= '0;
  end

  // R2
  level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == STS_LEVEL && !cfg_wr_i) |=> (sts_o == !$past(busy_i)));

  // R3
  erase_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == STS_ERASE && erase_done_i && !cfg_wr_i) |=> !sts_o);

  // R3
  erase_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == STS_ERASE && sts_o && !erase_done_i && !cfg_wr_i) |=> sts_o);

  // R4
  prog_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == STS_PROG && prog_done_i && !cfg_wr_i) |=> !sts_o);

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != STS_LEVEL && !sts_o) |-> (since_evt < PULSE_CYC));

  // R8
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_key_i != CFG_KEY) |=> (err_b5_o && err_b4_o && $stable(mode_i)));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_status_i && !(cfg_wr_i && cfg_key_i != CFG_KEY)) |=> (!err_b5_o && !err_b4_o));

  // R11
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_key_i == CFG_KEY) |=> (sts_o || mode_i == STS_LEVEL));

endmodule

bind rdy_status_pin rsp_chk #(
  .PULSE_CYC(PULSE_CYC), .DATA_W(DATA_W), .CFG_KEY(CFG_KEY)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_s),
  .busy_i      (busy_i),
  .erase_done_i(erase_done_i),
  .prog_done_i (prog_done_i),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_key_i   (cfg_key_i),
  .clr_status_i(clr_status_i),
  .mode_i      (mode_w),
  .sts_o       (sts_o),
  .err_b5_o    (err_b5_o),
  .err_b4_o    (err_b4_o)
);

// File: tb/tb_rdy_status_pin.sv
module tb_rdy_status_pin;

  localparam int        CLK_PERIOD = 10;
  localparam int        PW         = 8;
  localparam logic [7:0] KEY       = 8'h5C;

  logic       clk, rst_n, busy, ers, prg, wr, clr;
  logic [7:0] key, data;
  logic       sts, e5, e4;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [1:0] m_mode;
  logic       m_err, m_lvl;
  int         m_cnt;

  rdy_status_pin #(.PULSE_CYC(PW), .DATA_W(8), .CFG_KEY(KEY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .erase_done_i(ers),
    .prog_done_i(prg), .cfg_wr_i(wr), .cfg_key_i(key), .cfg_data_i(data),
    .clr_status_i(clr), .sts_o(sts), .err_b5_o(e5), .err_b4_o(e4)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_sts();
    return (m_mode == 2'b00) ? m_lvl : (m_cnt == 0);
  endfunction

  task automatic model_update();
    logic good, bad, fire;
    good = wr && (key == KEY);
    bad  = wr && (key != KEY);
    fire = (m_mode[0] && ers) || (m_mode[1] && prg);
    if (good)           m_cnt = 0;
    else if (fire)      m_cnt = PW;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (bad)      m_err = 1'b1;
    else if (clr) m_err = 1'b0;
    if (good) m_mode = data[1:0];
    m_lvl = ~busy;
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_val({tag, " pin"}, {31'd0, sts}, {31'd0, exp_sts()});
    check_val({tag, " err"}, {30'd0, e5, e4}, {30'd0, m_err, m_err});
    ers = 0; prg = 0; wr = 0; clr = 0;
  endtask

  task automatic write_cfg(logic [7:0] k, logic [7:0] d, string tag);
    wr = 1; key = k; data = d;
    step(tag);
  endtask

  task automatic count_low(string tag, output int n);
    n = (sts == 0) ? 1 : 0;
    while (sts == 0 && n < 200) begin
      step(tag);
      if (sts == 0) n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    rst_n = 0; busy = 0; ers = 0; prg = 0; wr = 0; clr = 0; key = 0; data = 0;
    m_mode = 2'b00; m_err = 0; m_lvl = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val("R1 pin in reset", {31'd0, sts}, 32'd1);
    check_val("R1 err in reset", {30'd0, e5, e4}, 32'd0);
    rst_n = 1;
    repeat (4) step("R1");

    // R2 level tracking, events ignored
    busy = 1; step("R2");
    check_val("R2 busy low", {31'd0, sts}, 32'd0);
    busy = 0; step("R2");
    check_val("R2 idle high", {31'd0, sts}, 32'd1);
    ers = 1; prg = 1; step("R2");
    check_val("R2 events ignored", {31'd0, sts}, 32'd1);

    // R9 reserved bits ignored: 0xFD selects code 01
    write_cfg(KEY, 8'hFD, "R9");
    prg = 1; step("R9");
    check_val("R9 code01 from 0xFD", {31'd0, sts}, 32'd1);

    // R3 / R6 erase pulse width
    ers = 1; step("R3");
    check_val("R3 erase pulses", {31'd0, sts}, 32'd0);
    count_low("R6", n);
    check_val("R6 width", n, PW);

    // R7 retrigger three cycles in
    ers = 1; step("R7");
    repeat (3) step("R7");
    ers = 1; step("R7");
    count_low("R7", n);
    check_val("R7 restarted length", n, PW);

    // R4 program only
    write_cfg(KEY, 8'h02, "R4");
    ers = 1; step("R4");
    check_val("R4 erase ignored", {31'd0, sts}, 32'd1);
    prg = 1; step("R4");
    check_val("R4 program pulses", {31'd0, sts}, 32'd0);
    count_low("R4", n);

    // R5 both
    write_cfg(KEY, 8'h03, "R5");
    ers = 1; step("R5");
    check_val("R5 erase pulses", {31'd0, sts}, 32'd0);
    count_low("R5", n);
    prg = 1; step("R5");
    check_val("R5 program pulses", {31'd0, sts}, 32'd0);

    // R11 write aborts active pulse, same-cycle event loses
    ers = 1; write_cfg(KEY, 8'h01, "R11");
    check_val("R11 abort", {31'd0, sts}, 32'd1);

    // R8 bad key: errors set, mode kept (erase still pulses)
    write_cfg(8'hA3, 8'h00, "R8");
    check_val("R8 errors", {30'd0, e5, e4}, 32'd3);
    ers = 1; step("R8");
    check_val("R8 mode kept", {31'd0, sts}, 32'd0);

    // R10 bad write beats clear, then clear works
    clr = 1; write_cfg(8'h00, 8'h00, "R10");
    check_val("R10 set wins", {30'd0, e5, e4}, 32'd3);
    step("R10");
    check_val("R10 sticky", {30'd0, e5, e4}, 32'd3);
    clr = 1; step("R10");
    check_val("R10 cleared", {30'd0, e5, e4}, 32'd0);

    // random mix across modes
    for (int i = 0; i < 4000; i++) begin
      busy = ($urandom % 4) == 0;
      ers  = ($urandom % 7) == 0;
      prg  = ($urandom % 6) == 0;
      clr  = ($urandom % 23) == 0;
      if (($urandom % 29) == 0) begin
        wr   = 1;
        key  = (($urandom % 4) == 0) ? 8'($urandom) : KEY;
        data = 8'($urandom);
      end
      step("RND R2-R11 mix");
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule